// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block keeps the processor's current interrupt priority level, a small field of the status word, and decides whether a pending interrupt request may be taken. A request is eligible only when its level is strictly above the current level. Eligibility is combinational, so the sequencer sees it in the same cycle the request is presented.

When the sequencer strobes acceptance of an eligible request, the block shows the outgoing level so that it can be written to the stack. On that clock edge it loads the request's level as the new current level. The only other way to change the level is a whole status-word restore from a stack pop, which takes the level from its field in the restored word. No single-field set or clear path exists. Reset puts the level at zero.

Top module: `ipl_gate`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the current level reads 0.
- R2: `eligible` is high exactly when `req_valid` is high and `req_level` is strictly greater than `cur_level`. An equal or lower level, or an invalid request, gives low.
- R3: A request at level 0 is never eligible, whatever the current level.
- R4: `saved_level` always shows the current level as it was before the coming clock edge, so that it can be pushed during acceptance.
- R5: On a clock edge where `accept` is high and `eligible` is high, the current level becomes `req_level`.
- R6: On a clock edge where `restore` is high and no eligible acceptance occurs, the current level becomes bits 10 down to 8 of `restore_word`. All other bits of the word have no effect.
- R7: If `restore` and an eligible acceptance happen on the same edge, the acceptance wins and the level becomes `req_level`.
- R8: With neither an eligible acceptance nor a restore, the current level keeps its value.
- R9: An `accept` strobe without an eligible request is ignored. If `restore` is high on that edge, the restore takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is pending |
| req_level | input | 3 | Priority level of the pending request |
| accept | input | 1 | Sequencer strobe that takes the pending request |
| restore | input | 1 | Load the level from a popped status word |
| restore_word | input | 16 | Popped status word; level in bits 10:8 |
| eligible | output | 1 | Pending request may be accepted |
| saved_level | output | 3 | Level to push on the stack on acceptance |
| cur_level | output | 3 | Current interrupt priority level |

## Verification
Every pair of current and request levels is tried with the request valid. This separates a strict comparison from one that admits equal levels, and it shows that level 0 is never eligible. Nested acceptances with rising levels show that the request's level, and not some other value, is loaded. Strobes that are ineligible or not valid show that no change happens without a real acceptance. Restores carry non-zero bits outside the level field, which exposes a wrong field slice. Restores that coincide with acceptance, eligible and ineligible, tell apart the two orders of priority between the update paths.

// File: rtl/ipl_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the interrupt priority level gate.
// Assumes: exactly one update source is chosen each cycle.
package ipl_pkg;
    // Source that drives the level register on the next edge
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_ACCEPT  = 2'd1,
        UPD_RESTORE = 2'd2
    } upd_src_e;
endpackage

// File: rtl/ipl_elig_cmp.sv
`timescale 1ns/1ps
// Module: ipl_elig_cmp
// Decides combinationally whether a pending request outranks the current level.
// Assumes: levels are unsigned; a higher value means a higher priority.
module ipl_elig_cmp #(
    parameter int LVL_W = 3
) (
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] cur_level,
    output logic             eligible
);
    logic above;

    // Strict comparison: an equal level is rejected
    always_comb begin
        above    = (req_level > cur_level);
        eligible = req_valid && above;
    end
endmodule

// File: rtl/ipl_level_reg.sv
`timescale 1ns/1ps
// Module: ipl_level_reg
// Holds the current priority level and loads it from the chosen source.
// Assumes: synchronous active-low reset; the source select is already resolved.
module ipl_level_reg
    import ipl_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_src_e         src,
    input  logic [LVL_W-1:0] take_level,
    input  logic [LVL_W-1:0] load_level,
    output logic [LVL_W-1:0] level_q
);
    logic [LVL_W-1:0] level_d;

    // Pick the next level from the update source
    always_comb begin
        unique case (src)
            UPD_ACCEPT:  level_d = take_level;
            UPD_RESTORE: level_d = load_level;
            default:     level_d = level_q;
        endcase
    end

    // Level register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end
endmodule

// File: rtl/ipl_gate.sv
`timescale 1ns/1ps
// Module: ipl_gate (top)
// Keeps the interrupt priority level, flags eligible requests, exposes the
// outgoing level for stacking, and swaps in the request level on acceptance.
// Assumes: accept is a one-cycle strobe from the sequencer; the level field of
// the restored status word starts at FIELD_LSB.
module ipl_gate
    import ipl_pkg::*;
#(
    parameter int LVL_W     = 3,
    parameter int WORD_W    = 16,
    parameter int FIELD_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              accept,
    input  logic              restore,
    input  logic [WORD_W-1:0] restore_word,
    output logic              eligible,
    output logic [LVL_W-1:0]  saved_level,
    output logic [LVL_W-1:0]  cur_level
);
    localparam int FIELD_MSB = FIELD_LSB + LVL_W - 1;

    upd_src_e         src;
    logic [LVL_W-1:0] field_level;
    logic             take;
    logic             unused_word_bits;

    // Only the level field of the word matters; the rest is folded away
    assign field_level      = restore_word[FIELD_MSB:FIELD_LSB];
    assign unused_word_bits = ^restore_word;

    ipl_elig_cmp #(.LVL_W(LVL_W)) u_cmp (
        .req_valid (req_valid),
        .req_level (req_level),
        .cur_level (cur_level),
        .eligible  (eligible)
    );

    // Acceptance outranks restore; a strobe with nothing eligible is dropped
    always_comb begin
        take = accept && eligible;
        if (take)         src = UPD_ACCEPT;
        else if (restore) src = UPD_RESTORE;
        else              src = UPD_HOLD;
    end

    ipl_level_reg #(.LVL_W(LVL_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (src),
        .take_level (req_level),
        .load_level (field_level),
        .level_q    (cur_level)
    );

    // The outgoing level is the register value ahead of the edge
    assign saved_level = cur_level;
endmodule

// File: rtl/ipl_gate_chk.sv
`timescale 1ns/1ps
// Module: ipl_gate_chk
// Property checker for ipl_gate, attached by bind below.
// Assumes: same parameters as the checked instance.
module ipl_gate_chk #(
    parameter int LVL_W     = 3,
    parameter int WORD_W    = 16,
    parameter int FIELD_LSB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LVL_W-1:0]  req_level,
    input logic              accept,
    input logic              restore,
    input logic [WORD_W-1:0] restore_word,
    input logic              eligible,
    input logic [LVL_W-1:0]  saved_level,
    input logic [LVL_W-1:0]  cur_level
);
    // R1: level is zero right after reset release
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cur_level == '0);

    // R2: an eligible request is valid and strictly higher
    p_elig_strict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eligible |-> (req_valid && req_level > cur_level));

    // R3: level 0 never passes
    p_zero_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_level == '0) |-> !eligible);

    // R4: the pushed value is the level before the edge
    p_save_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> saved_level == cur_level);

    // R5, R7: eligible acceptance loads the request level
    p_take_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eligible) |=> cur_level == $past(req_level));

    // R6, R9: restore loads the word's field when no acceptance occurs
    p_restore_r6_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !(accept && eligible)) |=>
            cur_level == $past(restore_word[FIELD_LSB +: LVL_W]));

    // R8: nothing else moves the level
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !(accept && eligible)) |=> $stable(cur_level));
endmodule

bind ipl_gate ipl_gate_chk #(
    .LVL_W(LVL_W), .WORD_W(WORD_W), .FIELD_LSB(FIELD_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .accept(accept), .restore(restore), .restore_word(restore_word),
    .eligible(eligible), .saved_level(saved_level), .cur_level(cur_level)
);

// File: tb/ipl_gate_bench.sv
`timescale 1ns/1ps
// Bench for ipl_gate: a behavioural reference level is stepped every clock
// and compared against the outputs a few ns after each falling edge.
module ipl_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_level = '0;
    logic        accept = 1'b0;
    logic        restore = 1'b0;
    logic [15:0] restore_word = '0;
    logic        eligible;
    logic [2:0]  saved_level;
    logic [2:0]  cur_level;

    int checks = 0;
    int errors = 0;
    int model_lvl = 0;
    string lvl_tag = "R1";

    always #4 clk = ~clk;

    ipl_gate u_ipl_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .accept(accept), .restore(restore), .restore_word(restore_word),
        .eligible(eligible), .saved_level(saved_level), .cur_level(cur_level)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive after the falling edge, check, then step the model
    task automatic cyc(input bit rv, input int rl, input bit acc, input bit rs, input int rlvl);
        int  elig;
        @(negedge clk);
        req_valid    = rv;
        req_level    = 3'(rl);
        accept       = acc;
        restore      = rs;
        restore_word = {5'b10101, 3'(rlvl), 8'hC3};
        #1;
        elig = (rv && rl > model_lvl) ? 1 : 0;
        check(lvl_tag, "cur_level", int'(cur_level), model_lvl);
        check((rl == 0) ? "R3" : "R2", "eligible", int'(eligible), elig);
        check("R4", "saved_level", int'(saved_level), model_lvl);
        if (acc && elig == 1) begin
            lvl_tag   = rs ? "R7" : "R5";
            model_lvl = rl;
        end else if (rs) begin
            lvl_tag   = acc ? "R9" : "R6";
            model_lvl = rlvl;
        end else begin
            lvl_tag = acc ? "R9" : "R8";
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        accept = 1'b0; restore = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R1", "cur_level in reset", int'(cur_level), 0);
        rst_n = 1'b1;
        model_lvl = 0;
        lvl_tag = "R1";
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // Full sweep of request level against current level (R2, R3, R6)
        for (int lv = 0; lv < 8; lv++) begin
            cyc(1'b0, 0, 1'b0, 1'b1, lv);
            for (int r = 0; r < 8; r++) cyc(1'b1, r, 1'b0, 1'b0, 0);
            cyc(1'b0, 7, 1'b0, 1'b0, 0);
        end
        // Invalid request, accept strobed: ignored (R9)
        cyc(1'b0, 0, 1'b0, 1'b1, 2);
        cyc(1'b0, 6, 1'b1, 1'b0, 0);
        // Equal level accept: ignored (R9)
        cyc(1'b1, 2, 1'b1, 1'b0, 0);
        // Nested rising acceptances (R4, R5)
        cyc(1'b1, 3, 1'b1, 1'b0, 0);
        cyc(1'b1, 5, 1'b1, 1'b0, 0);
        cyc(1'b1, 7, 1'b1, 1'b0, 0);
        cyc(1'b0, 0, 1'b0, 1'b0, 0);
        // Lower-level accept at 7: ignored (R9)
        cyc(1'b1, 4, 1'b1, 1'b0, 0);
        // Restore back down then accept and restore together (R6, R7)
        cyc(1'b0, 0, 1'b0, 1'b1, 1);
        cyc(1'b1, 6, 1'b1, 1'b1, 3);
        cyc(1'b0, 0, 1'b0, 1'b0, 0);
        // Ineligible accept with restore: restore wins (R9)
        cyc(1'b1, 2, 1'b1, 1'b1, 4);
        cyc(1'b0, 0, 1'b0, 1'b0, 0);
        // Restore to zero, then level-1 acceptance
        cyc(1'b0, 0, 1'b0, 1'b1, 0);
        cyc(1'b1, 1, 1'b1, 1'b0, 0);
        cyc(1'b0, 0, 1'b0, 1'b0, 0);
        // Mid-run reset (R1)
        cyc(1'b1, 6, 1'b1, 1'b0, 0);
        do_reset();
        cyc(1'b1, 0, 1'b1, 1'b0, 0);
        cyc(1'b1, 4, 1'b0, 1'b0, 0);
        cyc(1'b0, 0, 1'b0, 1'b0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule